// File: doc/BRIEF.md
# System control register block

This block holds a small set of chip-level control registers behind a 32-bit APB-style slave port, decoded over a 4 KB window. Software uses it to enable secure-debug features, read why the last reset happened, choose which reset causes are masked, keep one word of scratch state across warm resets, set the initial secure vector-table base, hold CPUs in a wait state, configure wake-up interrupt control, and request a system reset. A bank of constant identification words sits at the top of the window.

Two reset inputs are provided. The power-on reset clears every register. The warm reset restores every register except the retention word. The block itself does nothing with the control values beyond presenting them on output pins. The reset sequencer, debug authentication and stall logic live elsewhere.

The port has no back-pressure: the slave is always ready, finishes each access in its access phase with no wait states and never signals an error. Misuse of the map is reported through a separate one-cycle flag. The flag does not stall or fault the bus.

Top module: `sysctl_regblock`

## Requirements
- R1: After power-on reset, reads return 0 for debug status, 1 for reset cause, 0 for reset mask, 0 for retention, 0x1000_0000 for vector base, and 0 for CPU-wait and wake control. The output pins show the same values and both pulse outputs are low.
- R2: A write to offset 0x004 sets each debug-status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R3: A write to offset 0x008 clears each debug-status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: Offset 0x000 returns the debug status. A write to 0x000 does not change it and raises the illegal flag.
- R5: Reset cause (0x100), reset mask (0x104), retention (0x10C), vector base (0x110), CPU-wait (0x118) and wake control (0x120) read back the last full word written. Address bits [1:0] are ignored, so narrow accesses act on the whole word.
- R6: Offset 0x11C always reads 0. Reading it is legal. A write to it has no effect and raises the illegal flag.
- R7: A write to 0x108 with data bit 9 set makes rst_req high for exactly the one cycle after the completing clock edge. If bit 9 is clear, rst_req stays low. At all other times rst_req is low.
- R8: The twelve ID words at 0xFD0..0xFFC read, in address order, 0x04, 0x00, 0x00, 0x00, 0x54, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1, zero-extended.
- R9: Reads of 0x004, 0x008 and 0x108 return 0 and raise the illegal flag.
- R10: Unmapped offsets read 0 and raise the illegal flag on any access. A write to an unmapped offset changes no register.
- R11: A warm reset returns every register to its R1 value except retention, which keeps its content. Only power-on reset clears retention.
- R12: pready is always 1 and pslverr is always 0.
- R13: illegal_acc is high for exactly the one cycle after an access completes that breaks R4, R6, R9 or R10. It stays low after legal accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| warm_n | input | 1 | Warm reset, active low, asynchronous |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data, zero-padded by the master for narrow writes |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| sec_dbg | output | 32 | Debug-enable status bits |
| cpu_wait | output | 32 | CPU-wait control word |
| wake_ctrl | output | 32 | Wake-up interrupt control word |
| vtor_base | output | 32 | Initial secure vector-table base |
| rst_req | output | 1 | One-cycle system reset request |
| illegal_acc | output | 1 | One-cycle illegal-access flag |

## Verification
Read data is combinational from the current address, so it is due in the access-phase cycle itself. The bench captures it on the falling edge inside that cycle. rst_req, illegal_acc and the register output pins change on the rising edge that completes the access. The monitor compares them on the next falling edge, and it checks that both pulse outputs are low on every other falling edge outside reset. Resets are applied and released a short time after a falling edge, so no comparison falls on the same instant as an asynchronous reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_W = 12;
  localparam int WORD_W = ADDR_W - 2;

  // word offsets (byte offset >> 2)
  localparam logic [WORD_W-1:0] W_STAT    = 10'h000;
  localparam logic [WORD_W-1:0] W_SET     = 10'h001;
  localparam logic [WORD_W-1:0] W_CLR     = 10'h002;
  localparam logic [WORD_W-1:0] W_CAUSE   = 10'h040;
  localparam logic [WORD_W-1:0] W_MASK    = 10'h041;
  localparam logic [WORD_W-1:0] W_SWRST   = 10'h042;
  localparam logic [WORD_W-1:0] W_RETAIN  = 10'h043;
  localparam logic [WORD_W-1:0] W_VTOR    = 10'h044;
  localparam logic [WORD_W-1:0] W_CPUWAIT = 10'h046;
  localparam logic [WORD_W-1:0] W_BUSWAIT = 10'h047;
  localparam logic [WORD_W-1:0] W_WAKE    = 10'h048;
  localparam logic [WORD_W-1:0] W_ID_LO   = 10'h3F4;

  localparam int RST_REQ_BIT = 9;
  localparam int NUM_ID      = 12;

  // plain read/write bank indices
  localparam int NUM_RW     = 5;
  localparam int IX_CAUSE   = 0;
  localparam int IX_MASK    = 1;
  localparam int IX_VTOR    = 2;
  localparam int IX_CPUWAIT = 3;
  localparam int IX_WAKE    = 4;

  typedef enum logic [3:0] {
    RG_DBG_STAT,
    RG_DBG_SET,
    RG_DBG_CLR,
    RG_CAUSE,
    RG_MASK,
    RG_SWRST,
    RG_RETAIN,
    RG_VTOR,
    RG_CPUWAIT,
    RG_BUSWAIT,
    RG_WAKE,
    RG_ID,
    RG_NONE
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic       rd_ok;
    logic       wr_ok;
    logic [3:0] id_idx;
  } dec_t;

  // identification bytes, index 0 = lowest ID address
  function automatic logic [7:0] id_value(input logic [3:0] idx);
    logic [7:0] v;
    case (idx)
      4'd0:    v = 8'h04;
      4'd4:    v = 8'h54;
      4'd5:    v = 8'hB8;
      4'd6:    v = 8'h0B;
      4'd8:    v = 8'h0D;
      4'd9:    v = 8'hF0;
      4'd10:   v = 8'h05;
      4'd11:   v = 8'hB1;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);

  reg_sel_e sel;

  always_comb begin
    sel = RG_NONE;
    case (word)
      W_STAT:    sel = RG_DBG_STAT;
      W_SET:     sel = RG_DBG_SET;
      W_CLR:     sel = RG_DBG_CLR;
      W_CAUSE:   sel = RG_CAUSE;
      W_MASK:    sel = RG_MASK;
      W_SWRST:   sel = RG_SWRST;
      W_RETAIN:  sel = RG_RETAIN;
      W_VTOR:    sel = RG_VTOR;
      W_CPUWAIT: sel = RG_CPUWAIT;
      W_BUSWAIT: sel = RG_BUSWAIT;
      W_WAKE:    sel = RG_WAKE;
      default:   if (word >= W_ID_LO) sel = RG_ID;
    endcase
  end

  always_comb begin
    dec.sel    = sel;
    // ID window starts at a word whose low nibble is 4
    dec.id_idx = word[3:0] - 4'd4;
    case (sel)
      RG_DBG_SET, RG_DBG_CLR, RG_SWRST: begin
        dec.rd_ok = 1'b0;
        dec.wr_ok = 1'b1;
      end
      RG_DBG_STAT, RG_BUSWAIT, RG_ID: begin
        dec.rd_ok = 1'b1;
        dec.wr_ok = 1'b0;
      end
      RG_NONE: begin
        dec.rd_ok = 1'b0;
        dec.wr_ok = 1'b0;
      end
      default: begin
        dec.rd_ok = 1'b1;
        dec.wr_ok = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] VTOR_RST  = 32'h1000_0000,
  parameter logic [DATA_W-1:0] CAUSE_RST = 32'h0000_0001
) (
  input  logic                           clk,
  input  logic                           por_n,
  input  logic                           warm_n,
  input  logic                           wr_fire,
  input  reg_sel_e                       sel,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              dbg_q,
  output logic [NUM_RW-1:0][DATA_W-1:0]  rw_q,
  output logic [DATA_W-1:0]              retain_q
);

  localparam logic [DATA_W-1:0] ZERO = '0;
  localparam logic [NUM_RW-1:0][DATA_W-1:0] RW_RST =
    {ZERO, ZERO, VTOR_RST, ZERO, CAUSE_RST};
  localparam reg_sel_e RW_SEL [NUM_RW] =
    '{RG_CAUSE, RG_MASK, RG_VTOR, RG_CPUWAIT, RG_WAKE};

  logic sys_rst_n;
  assign sys_rst_n = por_n & warm_n;

  // plain read-as-written words
  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n)                      q <= RW_RST[g];
      else if (wr_fire && sel == RW_SEL[g]) q <= wdata;
    end
    assign rw_q[g] = q;
  end

  // debug status with set / clear aliases
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      dbg_q <= '0;
    end else if (wr_fire) begin
      if (sel == RG_DBG_SET)      dbg_q <= dbg_q | wdata;
      else if (sel == RG_DBG_CLR) dbg_q <= dbg_q & ~wdata;
    end
  end

  // retention word, cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                             retain_q <= '0;
    else if (wr_fire && sel == RG_RETAIN)   retain_q <= wdata;
  end

endmodule

// File: rtl/sysctl_strobe_gen.sv
module sysctl_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic req_d,
  input  logic ill_d,
  output logic rst_req,
  output logic illegal_acc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req     <= 1'b0;
      illegal_acc <= 1'b0;
    end else begin
      rst_req     <= req_d;
      illegal_acc <= ill_d;
    end
  end

endmodule

// File: rtl/sysctl_regblock.sv
module sysctl_regblock
  import sysctl_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] VTOR_RST  = 32'h1000_0000,
  parameter logic [DATA_W-1:0] CAUSE_RST = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic [DATA_W-1:0] sec_dbg,
  output logic [DATA_W-1:0] cpu_wait,
  output logic [DATA_W-1:0] wake_ctrl,
  output logic [DATA_W-1:0] vtor_base,
  output logic              rst_req,
  output logic              illegal_acc
);

  dec_t                          dec;
  logic                          access, acc_wr, acc_rd;
  logic [DATA_W-1:0]             dbg_q, retain_q, rdata_mux;
  logic [NUM_RW-1:0][DATA_W-1:0] rw_q;
  logic                          req_d, ill_d;
  logic                          unused_lsb;

  assign access     = psel & penable;
  assign acc_wr     = access & pwrite;
  assign acc_rd     = access & ~pwrite;
  assign unused_lsb = ^paddr[1:0];

  sysctl_addr_dec u_dec (
    .word (paddr[ADDR_W-1:2]),
    .dec  (dec)
  );

  sysctl_regs #(
    .DATA_W    (DATA_W),
    .VTOR_RST  (VTOR_RST),
    .CAUSE_RST (CAUSE_RST)
  ) u_regs (
    .clk      (clk),
    .por_n    (por_n),
    .warm_n   (warm_n),
    .wr_fire  (acc_wr),
    .sel      (dec.sel),
    .wdata    (pwdata),
    .dbg_q    (dbg_q),
    .rw_q     (rw_q),
    .retain_q (retain_q)
  );

  always_comb begin
    rdata_mux = '0;
    case (dec.sel)
      RG_DBG_STAT: rdata_mux = dbg_q;
      RG_CAUSE:    rdata_mux = rw_q[IX_CAUSE];
      RG_MASK:     rdata_mux = rw_q[IX_MASK];
      RG_RETAIN:   rdata_mux = retain_q;
      RG_VTOR:     rdata_mux = rw_q[IX_VTOR];
      RG_CPUWAIT:  rdata_mux = rw_q[IX_CPUWAIT];
      RG_WAKE:     rdata_mux = rw_q[IX_WAKE];
      RG_ID:       rdata_mux = DATA_W'(id_value(dec.id_idx));
      default:     rdata_mux = '0;
    endcase
  end

  assign prdata  = (psel && !pwrite) ? rdata_mux : '0;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  assign req_d = acc_wr && (dec.sel == RG_SWRST) && pwdata[RST_REQ_BIT];
  assign ill_d = (acc_wr && !dec.wr_ok) || (acc_rd && !dec.rd_ok);

  sysctl_strobe_gen u_strobe (
    .clk         (clk),
    .rst_n       (por_n & warm_n),
    .req_d       (req_d),
    .ill_d       (ill_d),
    .rst_req     (rst_req),
    .illegal_acc (illegal_acc)
  );

  assign sec_dbg   = dbg_q;
  assign cpu_wait  = rw_q[IX_CPUWAIT];
  assign wake_ctrl = rw_q[IX_WAKE];
  assign vtor_base = rw_q[IX_VTOR];

endmodule

// File: rtl/sysctl_regblock_chk.sv
module sysctl_regblock_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              warm_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [9:0]        word,
  input logic              req_bit,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [DATA_W-1:0] sec_dbg,
  input logic [DATA_W-1:0] cpu_wait,
  input logic [DATA_W-1:0] vtor_base,
  input logic              rst_req,
  input logic              illegal_acc
);

  logic live, wr, rd;
  assign live = por_n & warm_n;
  assign wr   = psel & penable & pwrite;
  assign rd   = psel & penable & ~pwrite;

  p_no_wait_r12: assert property (@(posedge clk) disable iff (!live)
    pready && !pslverr);

  p_req_single_r7: assert property (@(posedge clk) disable iff (!live)
    rst_req |=> !rst_req);

  p_req_source_r7: assert property (@(posedge clk) disable iff (!live)
    rst_req |-> $past(wr && word == 10'h042 && req_bit));

  p_stat_guard_r4: assert property (@(posedge clk) disable iff (!live)
    !$stable(sec_dbg) |-> $past(wr && (word == 10'h001 || word == 10'h002)));

  p_vtor_guard_r5: assert property (@(posedge clk) disable iff (!live)
    !$stable(vtor_base) |-> $past(wr && word == 10'h044));

  p_wait_guard_r5: assert property (@(posedge clk) disable iff (!live)
    !$stable(cpu_wait) |-> $past(wr && word == 10'h046));

  p_flag_source_r13: assert property (@(posedge clk) disable iff (!live)
    illegal_acc |-> $past(psel && penable));

  p_wo_reads_zero_r9: assert property (@(posedge clk) disable iff (!live)
    (rd && (word == 10'h001 || word == 10'h002 || word == 10'h042)) |-> prdata == '0);

  p_buswait_zero_r6: assert property (@(posedge clk) disable iff (!live)
    (rd && word == 10'h047) |-> prdata == '0);

endmodule

bind sysctl_regblock sysctl_regblock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .warm_n      (warm_n),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .word        (paddr[11:2]),
  .req_bit     (pwdata[9]),
  .prdata      (prdata),
  .pready      (pready),
  .pslverr     (pslverr),
  .sec_dbg     (sec_dbg),
  .cpu_wait    (cpu_wait),
  .vtor_base   (vtor_base),
  .rst_req     (rst_req),
  .illegal_acc (illegal_acc)
);

// File: tb/tb_sysctl_regblock.sv
module tb_sysctl_regblock;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, warm_n = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, sec_dbg, cpu_wait, wake_ctrl, vtor_base;
  logic        pready, pslverr, rst_req, illegal_acc;

  always #2 clk = ~clk;

  sysctl_regblock dut (
    .clk(clk), .por_n(por_n), .warm_n(warm_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr),
    .sec_dbg(sec_dbg), .cpu_wait(cpu_wait), .wake_ctrl(wake_ctrl),
    .vtor_base(vtor_base), .rst_req(rst_req), .illegal_acc(illegal_acc)
  );

  int n_chk = 0;
  int n_fail = 0;

  function automatic void check(bit ok, string req, logic [31:0] act, logic [31:0] exp,
                                string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endfunction

  typedef struct {
    bit          is_rd;
    logic [31:0] exp_d;
    bit          exp_ill;
    bit          exp_rq;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic        done_pending = 1'b0;
  logic [31:0] cap_rd = '0;

  always @(posedge clk) done_pending <= psel && penable;

  // monitor: data in the access phase, pulses one cycle after completion
  always @(negedge clk) begin
    item_t it;
    if (psel && penable) begin
      cap_rd = prdata;
      check(pready === 1'b1 && pslverr === 1'b0, "R12", {30'd0, pready, pslverr},
            32'h2, "handshake");
    end
    if (done_pending) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R13", 32'd0, 32'd1, "scoreboard empty");
      end else begin
        it = sb_q.pop_front();
        if (it.is_rd) check(cap_rd === it.exp_d, it.tag, cap_rd, it.exp_d, "read data");
        check(illegal_acc === it.exp_ill, it.tag, {31'd0, illegal_acc},
              {31'd0, it.exp_ill}, "illegal flag (R13)");
        check(rst_req === it.exp_rq, it.tag, {31'd0, rst_req}, {31'd0, it.exp_rq},
              "reset request (R7)");
      end
    end else if (por_n && warm_n) begin
      check(rst_req === 1'b0 && illegal_acc === 1'b0, "R7", {30'd0, rst_req, illegal_acc},
            32'd0, "idle pulses");
    end
  end

  task automatic apb(input bit w, input logic [11:0] a, input logic [31:0] d,
                     input logic [31:0] exp, input bit ill, input bit rq, input string tag);
    item_t it;
    it.is_rd = !w; it.exp_d = exp; it.exp_ill = ill; it.exp_rq = rq; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = w ? d : 32'd0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit ill, input bit rq,
                    input string tag);
    apb(1'b1, a, d, 32'd0, ill, rq, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input bit ill,
                    input string tag);
    apb(1'b0, a, 32'd0, exp, ill, 1'b0, tag);
  endtask

  task automatic pulse_reset(input bit power);
    repeat (2) @(negedge clk);
    #1;
    if (power) por_n = 1'b0; else warm_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    por_n = 1'b1; warm_n = 1'b1;
    @(negedge clk);
  endtask

  localparam logic [7:0] ID_EXP [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h54, 8'hB8,
                                         8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R12", 32'd0, 32'd1, "watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 por_n = 1'b1;
    @(negedge clk);
    // R1: pins right after power-on
    check(sec_dbg === 32'd0, "R1", sec_dbg, 32'd0, "sec_dbg pin");
    check(vtor_base === 32'h1000_0000, "R1", vtor_base, 32'h1000_0000, "vtor pin");
    check(cpu_wait === 32'd0 && wake_ctrl === 32'd0, "R1", cpu_wait | wake_ctrl, 32'd0,
          "wait/wake pins");
    check(rst_req === 1'b0 && illegal_acc === 1'b0, "R1", {30'd0, rst_req, illegal_acc},
          32'd0, "pulses low");
    rd(12'h000, 32'd0, 0, "R1");
    rd(12'h100, 32'd1, 0, "R1");
    rd(12'h104, 32'd0, 0, "R1");
    rd(12'h10C, 32'd0, 0, "R1");
    rd(12'h110, 32'h1000_0000, 0, "R1");
    rd(12'h118, 32'd0, 0, "R1");
    rd(12'h120, 32'd0, 0, "R1");

    // R2 / R3 / R4: set, clear, read-only status
    wr(12'h004, 32'h0000_00A5, 0, 0, "R2");
    rd(12'h000, 32'h0000_00A5, 0, "R2");
    wr(12'h004, 32'h0000_0F00, 0, 0, "R2");
    rd(12'h000, 32'h0000_0FA5, 0, "R2");
    wr(12'h008, 32'h0000_0081, 0, 0, "R3");
    rd(12'h000, 32'h0000_0F24, 0, "R3");
    wr(12'h000, 32'hFFFF_FFFF, 1, 0, "R4");
    rd(12'h000, 32'h0000_0F24, 0, "R4");
    @(negedge clk);
    check(sec_dbg === 32'h0000_0F24, "R4", sec_dbg, 32'h0000_0F24, "sec_dbg pin");

    // R5: read-as-written words
    wr(12'h100, 32'hDEAD_0003, 0, 0, "R5");
    wr(12'h104, 32'h0000_5A5A, 0, 0, "R5");
    wr(12'h10C, 32'hCAFE_F00D, 0, 0, "R5");
    wr(12'h110, 32'h0020_0000, 0, 0, "R5");
    wr(12'h118, 32'h0000_0001, 0, 0, "R5");
    wr(12'h121, 32'h0000_0003, 0, 0, "R5");
    rd(12'h100, 32'hDEAD_0003, 0, "R5");
    rd(12'h102, 32'hDEAD_0003, 0, "R5");
    rd(12'h104, 32'h0000_5A5A, 0, "R5");
    rd(12'h10C, 32'hCAFE_F00D, 0, "R5");
    rd(12'h110, 32'h0020_0000, 0, "R5");
    rd(12'h118, 32'h0000_0001, 0, "R5");
    rd(12'h120, 32'h0000_0003, 0, "R5");
    @(negedge clk);
    check(vtor_base === 32'h0020_0000, "R5", vtor_base, 32'h0020_0000, "vtor pin");
    check(cpu_wait === 32'd1, "R5", cpu_wait, 32'd1, "cpu_wait pin");
    check(wake_ctrl === 32'd3, "R5", wake_ctrl, 32'd3, "wake pin");

    // R6: bus-wait word
    wr(12'h11C, 32'hFFFF_FFFF, 1, 0, "R6");
    rd(12'h11C, 32'd0, 0, "R6");

    // R7: reset request bit 9 only
    wr(12'h108, 32'h0000_0200, 0, 1, "R7");
    wr(12'h108, 32'hFFFF_FDFF, 0, 0, "R7");
    wr(12'h108, 32'hFFFF_FFFF, 0, 1, "R7");

    // R8: identification words
    for (int i = 0; i < 12; i++)
      rd(12'hFD0 + 12'(4 * i), {24'd0, ID_EXP[i]}, 0, "R8");
    wr(12'hFE0, 32'h1234_5678, 1, 0, "R8");
    rd(12'hFE0, 32'h0000_0054, 0, "R8");

    // R9: write-only offsets read zero
    rd(12'h004, 32'd0, 1, "R9");
    rd(12'h008, 32'd0, 1, "R9");
    rd(12'h108, 32'd0, 1, "R9");

    // R10: unmapped offsets
    wr(12'h200, 32'hFFFF_FFFF, 1, 0, "R10");
    wr(12'h114, 32'hFFFF_FFFF, 1, 0, "R10");
    rd(12'h200, 32'd0, 1, "R10");
    rd(12'h114, 32'd0, 1, "R10");
    rd(12'hFCC, 32'd0, 1, "R10");
    rd(12'h100, 32'hDEAD_0003, 0, "R10");
    rd(12'h110, 32'h0020_0000, 0, "R10");
    rd(12'h000, 32'h0000_0F24, 0, "R10");

    // R11: warm reset keeps retention, power-on clears it
    pulse_reset(1'b0);
    check(sec_dbg === 32'd0, "R11", sec_dbg, 32'd0, "sec_dbg after warm");
    check(vtor_base === 32'h1000_0000, "R11", vtor_base, 32'h1000_0000, "vtor after warm");
    rd(12'h000, 32'd0, 0, "R11");
    rd(12'h100, 32'd1, 0, "R11");
    rd(12'h104, 32'd0, 0, "R11");
    rd(12'h10C, 32'hCAFE_F00D, 0, "R11");
    rd(12'h118, 32'd0, 0, "R11");
    rd(12'h120, 32'd0, 0, "R11");
    pulse_reset(1'b1);
    rd(12'h10C, 32'd0, 0, "R11");
    rd(12'h110, 32'h1000_0000, 0, "R11");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R13", sb_q.size(), 32'd0, "scoreboard drained");
    finish_run();
  end

endmodule